// File: doc/BRIEF.md
# Audio Serial Transmitter with Sample FIFO

This block sends audio samples out of a chip in the usual three-wire stereo serial format: a bit clock, a word-select (channel) clock and one data line. Software reaches it through a small synchronous register port that is addressed by word index. Sample words written to the data register go into a transmit FIFO. While transmission is enabled, a serialiser pops one word at the start of each channel slot and shifts it out MSB first.

The block's clock is the master audio clock. The bit clock is that clock divided by a programmable ratio. The frame length, counted in bit clocks, is also programmable. This makes 16-bit and 24-bit stereo work at any frame size. A sticky flag records that the FIFO ran dry during transmission, and a clear register empties the FIFO and restarts the serialiser.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset the register port reads back the following values. Word 0 (sample width minus one, bits [4:0]) reads 15. Word 2 (dividers) reads 0x00071F1F, which is ratio-minus-one 7 in bits [23:16], receive frame-minus-one 31 in [15:8] and transmit frame-minus-one 31 in [7:0]. Words 1, 3, 6 and 7 read 0. Words 4, 5, 8, 9 and 10 always read 0.
- R2: Writes are kept only in the defined bits. Word 1 (receive control) stores all 32 bits. Word 0 stores bits [4:0]. Word 2 stores bits [23:0]. Word 7 (run control) stores bits [1:0]. All other bits read back as 0.
- R3: Run-control bit 1 (receive enable) is stored and read back. It has no effect on the bit clock, the word clock or the data line.
- R4: While run-control bit 0 is 0, the bit clock, word clock and data line stay low and no word leaves the FIFO.
- R5: While running, the bit-clock period is the ratio field plus one clock cycles. The bit clock is high for the last half of each period. A frame lasts the transmit frame field plus one bit clocks. The word clock is low for the first half of the frame (left channel) and high for the second half (right channel).
- R6: The FIFO holds 32 words, and word 3 bits [5:0] report its fill level. A write to word 9 while the FIFO is full is dropped, and the level stays at 32.
- R7: Each channel slot carries the low (width field plus one) bits of one FIFO word, MSB first. The MSB goes out one bit clock after the word-clock edge. The data line changes only on falling bit-clock edges, and slot bits after the LSB are 0. Words are sent in FIFO order, left channel first.
- R8: If the FIFO is empty when a slot starts, the slot sends zeros and word 6 bit 0 is set. That bit stays set until a 1 is written to word 6 bit 0. Writing 0 to it has no effect.
- R9: Any write to word 8 empties the FIFO and returns the serialiser to its start-of-frame state, with the bit clock and the word clock low.
- R10: Sample widths other than 16 work as well. With width field 23 and a 48-bit frame, each slot carries the low 24 bits of its word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock, also the register port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Word (channel) clock, low for the left channel |
| sdo_o | output | 1 | Serial data |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 32-deep FIFO and 8-bit divider fields. This puts the level field's full range, and saturation at 32, within reach of one overflow test. The divider values are changed at run time: ratios of 8, 4 and 2 with frames of 32, 48 and 64 bit clocks. These settings cover the default stereo point, 24-bit samples, and 16-bit samples padded into 32-bit slots. A bench-side receiver decodes the serial lines independently of the RTL. It checks the bit-clock period and the slot length as it goes.

// File: rtl/audio_tx_pkg.sv
`timescale 1ns/1ps
// audio_tx_pkg: register word indices and reset defaults shared by the
// audio serial transmitter. Assumes a 4-bit word index on the register port.
package audio_tx_pkg;

    localparam int IDX_W = 4;

    typedef enum logic [IDX_W-1:0] {
        RI_WIDTH   = 4'd0,
        RI_RXCFG   = 4'd1,
        RI_CLKDIV  = 4'd2,
        RI_LEVEL   = 4'd3,
        RI_DMACFG  = 4'd4,
        RI_IRQCFG  = 4'd5,
        RI_STATUS  = 4'd6,
        RI_RUN     = 4'd7,
        RI_FLUSH   = 4'd8,
        RI_PUSH    = 4'd9,
        RI_RXWORD  = 4'd10
    } reg_idx_e;

    localparam logic [7:0] RST_WIDTH_M1 = 8'd15;
    localparam logic [7:0] RST_RATIO_M1 = 8'd7;
    localparam logic [7:0] RST_FRAME_M1 = 8'd31;

endpackage

// File: rtl/atx_regfile.sv
`timescale 1ns/1ps
// atx_regfile: register port decode, configuration storage, sticky
// underflow status and read mux. Assumes DIV_W <= 8 and WID_W <= 8 so the
// divider fields fit their 8-bit lanes of the divider word.
module atx_regfile
    import audio_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 6,
    parameter int DIV_W  = 8,
    parameter int WID_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              underflow_evt,
    output logic [WID_W-1:0]  width_m1,
    output logic [DIV_W-1:0]  ratio_m1,
    output logic [DIV_W-1:0]  tx_frame_m1,
    output logic              tx_en,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_flush
);

    reg_idx_e          idx;
    logic              wr_hit;
    logic              clr_stat;
    logic [DIV_W-1:0]  rx_frame_m1;
    logic [DATA_W-1:0] rx_cfg;
    logic              rx_en;
    logic              uflow_q;

    // Decode the word index and the write strobes.
    always_comb begin
        idx        = reg_idx_e'(bus_addr);
        wr_hit     = bus_sel && bus_wr;
        fifo_push  = wr_hit && (idx == RI_PUSH);
        fifo_flush = wr_hit && (idx == RI_FLUSH);
        clr_stat   = wr_hit && (idx == RI_STATUS) && bus_wdata[0];
        fifo_wdata = bus_wdata;
    end

    // Configuration registers written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_m1    <= WID_W'(RST_WIDTH_M1);
            ratio_m1    <= DIV_W'(RST_RATIO_M1);
            rx_frame_m1 <= DIV_W'(RST_FRAME_M1);
            tx_frame_m1 <= DIV_W'(RST_FRAME_M1);
            rx_cfg      <= '0;
            tx_en       <= 1'b0;
            rx_en       <= 1'b0;
        end else if (wr_hit) begin
            case (idx)
                RI_WIDTH:  width_m1 <= bus_wdata[WID_W-1:0];
                RI_RXCFG:  rx_cfg   <= bus_wdata;
                RI_CLKDIV: begin
                    ratio_m1    <= bus_wdata[16 +: DIV_W];
                    rx_frame_m1 <= bus_wdata[8 +: DIV_W];
                    tx_frame_m1 <= bus_wdata[0 +: DIV_W];
                end
                RI_RUN: begin
                    tx_en <= bus_wdata[0];
                    rx_en <= bus_wdata[1];
                end
                default: ;
            endcase
        end
    end

    // Sticky underflow flag: set by the serialiser, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n)             uflow_q <= 1'b0;
        else if (underflow_evt) uflow_q <= 1'b1;
        else if (clr_stat)      uflow_q <= 1'b0;
    end

    // Read mux; out-of-scope and write-only words return zero.
    always_comb begin
        bus_rdata = '0;
        case (idx)
            RI_WIDTH:  bus_rdata[WID_W-1:0] = width_m1;
            RI_RXCFG:  bus_rdata = rx_cfg;
            RI_CLKDIV: begin
                bus_rdata[16 +: DIV_W] = ratio_m1;
                bus_rdata[8 +: DIV_W]  = rx_frame_m1;
                bus_rdata[0 +: DIV_W]  = tx_frame_m1;
            end
            RI_LEVEL:  bus_rdata[LVL_W-1:0] = fifo_level;
            RI_STATUS: bus_rdata[0] = uflow_q;
            RI_RUN:    bus_rdata[1:0] = {rx_en, tx_en};
            default:   bus_rdata = '0;
        endcase
    end

    // R8: the flag holds unless a 1 is written to bit 0.
    p_uflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow_q && !clr_stat) |=> uflow_q);

endmodule

// File: rtl/atx_fifo.sv
`timescale 1ns/1ps
// atx_fifo: transmit sample FIFO with fill level. A push while full is
// dropped. The caller pops only when not empty. Flush empties the FIFO in one
// cycle. DEPTH need not be a power of two.
module atx_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic [LVL_W-1:0]  level
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              full, push_ok, pop_ok;

    // Status and accepted operations.
    always_comb begin
        full    = (level == LVL_W'(DEPTH));
        empty   = (level == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = mem[rptr];
    end

    // Storage array, written on accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    // Pointers and level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R6: the level never passes the depth.
    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R6: a push into a full FIFO without a pop leaves it full.
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(DEPTH) && push && !pop && !flush) |=> level == LVL_W'(DEPTH));

endmodule

// File: rtl/atx_sclk_gen.sv
`timescale 1ns/1ps
// atx_sclk_gen: divides the master clock into the bit clock. The phase
// counter runs 0..ratio_m1. The bit clock is high in the upper half of that
// range. A falling-edge event marks the wrap. Idle holds phase 0, clock low.
module atx_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio_m1,
    output logic             sclk,
    output logic             fall
);

    logic [DIV_W-1:0] phase;
    logic [DIV_W:0]   ratio;
    logic [DIV_W:0]   hi_from;
    logic             at_end;

    // Threshold and wrap detection.
    always_comb begin
        ratio   = {1'b0, ratio_m1} + 1'b1;
        hi_from = ratio >> 1;
        at_end  = (phase >= ratio_m1);
        sclk    = run && ({1'b0, phase} >= hi_from);
        fall    = run && at_end;
    end

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) phase <= '0;
        else if (at_end)    phase <= '0;
        else                phase <= phase + 1'b1;
    end

    // R5: the wrap (falling edge) happens only from the high half.
    p_fall_from_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> sclk);

endmodule

// File: rtl/atx_shifter.sv
`timescale 1ns/1ps
// atx_shifter: frame-slot counter, word clock and data shifter. All state
// moves on bit-clock falling-edge events. A slot starts at slot index 0 and
// at half the frame. At a slot start the old MSB of the shift register goes
// out (the previous LSB, giving the one-bit delay) and a new word is loaded
// MSB-aligned, or zero if the FIFO is empty. Assumes width_m1 < DATA_W.
module atx_shifter #(
    parameter int DATA_W = 32,
    parameter int FRM_W  = 8,
    parameter int WID_W  = 5,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fall,
    input  logic [FRM_W-1:0]  frame_m1,
    input  logic [WID_W-1:0]  width_m1,
    input  logic [DATA_W-1:0] head,
    input  logic              empty,
    output logic              pop,
    output logic              underflow,
    output logic              lrck,
    output logic              sdo
);

    logic [FRM_W-1:0]  slot_q, slot_nxt;
    logic [FRM_W:0]    half;
    logic              ch_start;
    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] aligned, shreg;

    // Next slot index, channel boundary and alignment of the new word.
    always_comb begin
        half      = ({1'b0, frame_m1} + 1'b1) >> 1;
        slot_nxt  = (slot_q >= frame_m1) ? '0 : slot_q + 1'b1;
        ch_start  = (slot_nxt == '0) || ({1'b0, slot_nxt} == half);
        shamt     = SH_W'(DATA_W - 1) - SH_W'(width_m1);
        aligned   = head << shamt;
        pop       = fall && ch_start && !empty;
        underflow = fall && ch_start && empty;
    end

    // Slot counter, word clock, data bit and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            slot_q <= frame_m1;
            lrck   <= 1'b0;
            sdo    <= 1'b0;
            shreg  <= '0;
        end else if (fall) begin
            slot_q <= slot_nxt;
            lrck   <= ({1'b0, slot_nxt} >= half);
            sdo    <= shreg[DATA_W-1];
            if (ch_start) shreg <= empty ? '0 : aligned;
            else          shreg <= shreg << 1;
        end
    end

    // R7: the data line moves only on a falling-edge event or when idling.
    p_sdo_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall || !run));

    // R5: the word clock moves only on a falling-edge event or when idling.
    p_lrck_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck) |-> $past(fall || !run));

endmodule

// File: rtl/audio_serial_tx.sv
`timescale 1ns/1ps
// audio_serial_tx: register-controlled stereo serial audio transmitter.
// The clock input is the master audio clock. The register port is
// synchronous to it. Composes register file, FIFO, bit-clock divider and
// shifter. A flush write idles the serialiser for one cycle, which restarts
// it from frame start.
module audio_serial_tx
    import audio_tx_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 32,
    parameter int DIV_W      = 8,
    parameter int WID_W      = 5,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    output logic              lrck_o,
    output logic              sdo_o
);

    logic [WID_W-1:0]  width_m1;
    logic [DIV_W-1:0]  ratio_m1, tx_frame_m1;
    logic              tx_en, push, flush, pop, empty, underflow, fall, run;
    logic [DATA_W-1:0] push_data, head;
    logic [LVL_W-1:0]  level;

    // Serialiser runs while enabled and not being flushed.
    always_comb run = tx_en && !flush;

    atx_regfile #(
        .DATA_W(DATA_W), .LVL_W(LVL_W), .DIV_W(DIV_W), .WID_W(WID_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_level(level), .underflow_evt(underflow),
        .width_m1(width_m1), .ratio_m1(ratio_m1), .tx_frame_m1(tx_frame_m1),
        .tx_en(tx_en), .fifo_push(push), .fifo_wdata(push_data),
        .fifo_flush(flush)
    );

    atx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push), .wdata(push_data),
        .pop(pop), .head(head), .empty(empty), .level(level)
    );

    atx_sclk_gen #(.DIV_W(DIV_W)) i_sclk (
        .clk(clk), .rst_n(rst_n), .run(run), .ratio_m1(ratio_m1),
        .sclk(sclk_o), .fall(fall)
    );

    atx_shifter #(.DATA_W(DATA_W), .FRM_W(DIV_W), .WID_W(WID_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .run(run), .fall(fall),
        .frame_m1(tx_frame_m1), .width_m1(width_m1),
        .head(head), .empty(empty),
        .pop(pop), .underflow(underflow), .lrck(lrck_o), .sdo(sdo_o)
    );

    // R4: with transmit disabled the bit clock is low and nothing is popped.
    p_gated_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!sclk_o && !pop));

endmodule

// File: tb/test_audio_serial_tx.sv
`timescale 1ns/1ps
module test_audio_serial_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk_o, lrck_o, sdo_o;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    audio_serial_tx i_audio_serial_tx (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .lrck_o(lrck_o), .sdo_o(sdo_o)
    );

    // Independent serial receiver, sampling at rising bit-clock edges.
    int          exp_ratio = 8, exp_half = 16, exp_w = 16;
    logic        dec_rst = 1'b0;
    longint      cyc = 0, last_rise = 0, rises = 0;
    int          period_err = 0, half_err = 0, dec_n = 0, bit_cnt = 0;
    bit          have_rise = 0, first_done = 0, sclk_prev = 0, lrck_seen = 0;
    logic [63:0] acc = '0;
    logic [31:0] dec [64];

    always @(negedge clk) begin
        logic [63:0] cap, word;
        int nb;
        cyc++;
        if (dec_rst) begin
            have_rise = 0; first_done = 0; lrck_seen = 0; acc = '0;
            bit_cnt = 0; dec_n = 0; period_err = 0; half_err = 0;
            sclk_prev = sclk_o;
        end else begin
            if (sclk_o && !sclk_prev) begin
                rises++;
                if (have_rise && (cyc - last_rise) != longint'(exp_ratio)) period_err++;
                have_rise = 1; last_rise = cyc;
                nb = bit_cnt + 1;
                if (lrck_o != lrck_seen) begin
                    cap = {acc[62:0], sdo_o};
                    if (first_done && nb != exp_half) half_err++;
                    first_done = 1;
                    word = cap & ((64'd1 << exp_half) - 64'd1);
                    word = word >> (exp_half - exp_w);
                    if (dec_n < 64) dec[dec_n] = word[31:0];
                    dec_n++;
                    acc = '0; bit_cnt = 0;
                end else begin
                    acc = {acc[62:0], sdo_o};
                    bit_cnt = nb;
                end
                lrck_seen = lrck_o;
            end
            sclk_prev = sclk_o;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic restart_decoder(input int ratio, input int half, input int w);
        exp_ratio = ratio; exp_half = half; exp_w = w;
        dec_rst = 1'b1;
        @(negedge clk);
        #1 dec_rst = 1'b0;
    endtask

    task automatic wait_words(input int n);
        for (int i = 0; i < 20000 && dec_n < n; i++) @(posedge clk);
    endtask

    // {write, index, write data, expected read data}
    localparam int NV = 21;
    localparam logic [68:0] VEC [NV] = '{
        {1'b0, 4'd0,  32'h0,         32'h0000000F},  // R1
        {1'b0, 4'd1,  32'h0,         32'h00000000},  // R1
        {1'b0, 4'd2,  32'h0,         32'h00071F1F},  // R1
        {1'b0, 4'd3,  32'h0,         32'h00000000},  // R1
        {1'b0, 4'd4,  32'h0,         32'h00000000},  // R1
        {1'b0, 4'd5,  32'h0,         32'h00000000},  // R1
        {1'b0, 4'd6,  32'h0,         32'h00000000},  // R1
        {1'b0, 4'd7,  32'h0,         32'h00000000},  // R1
        {1'b0, 4'd8,  32'h0,         32'h00000000},  // R1
        {1'b0, 4'd9,  32'h0,         32'h00000000},  // R1
        {1'b0, 4'd10, 32'h0,         32'h00000000},  // R1
        {1'b1, 4'd1,  32'hA5A50017,  32'h0},         // R2
        {1'b0, 4'd1,  32'h0,         32'hA5A50017},
        {1'b1, 4'd0,  32'hFFFFFFF7,  32'h0},
        {1'b0, 4'd0,  32'h0,         32'h00000017},
        {1'b1, 4'd2,  32'hFF112233,  32'h0},
        {1'b0, 4'd2,  32'h0,         32'h00112233},
        {1'b1, 4'd0,  32'h0000000F,  32'h0},
        {1'b1, 4'd2,  32'h00071F1F,  32'h0},
        {1'b1, 4'd7,  32'hFFFFFFFE,  32'h0},         // R3
        {1'b0, 4'd7,  32'h0,         32'h00000002}
    };

    logic [31:0] rd;
    logic [31:0] words [34];

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Register vectors: reset values and field masking (R1, R2, R3).
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][68]) bus_write(VEC[v][67:64], VEC[v][63:32]);
            else begin
                bus_read(VEC[v][67:64], rd);
                check((v < 11) ? "R1 reset value" : "R2/R3 readback", rd, VEC[v][31:0]);
            end
        end

        // R3: receive enable alone leaves the serial lines idle.
        begin
            longint r0 = rises;
            repeat (100) @(posedge clk);
            @(negedge clk);
            check("R3 no bit clock with rx enable", 32'(rises - r0), 0);
            check("R3 word clock idle", {31'b0, lrck_o}, 0);
        end
        bus_write(4'd7, 32'h0);

        // R4: preloaded words stay while transmit is disabled.
        for (int i = 0; i < 5; i++) words[i] = 32'hC0DE0000 + 32'(i * 32'h1111) + 32'h0F0F;
        for (int i = 0; i < 5; i++) bus_write(4'd9, words[i]);
        begin
            longint r0 = rises;
            repeat (200) @(posedge clk);
            @(negedge clk);
            check("R4 no bit clock while disabled", 32'(rises - r0), 0);
            check("R4 data and word clock low", {30'b0, lrck_o, sdo_o}, 0);
            bus_read(4'd3, rd);
            check("R4 FIFO not drained", rd, 5);
        end

        // R5, R7, R8: default stereo stream then underflow.
        restart_decoder(8, 16, 16);
        bus_write(4'd7, 32'h1);
        wait_words(7);
        for (int i = 0; i < 5; i++) check("R7 sample order and content", dec[i], words[i] & 32'hFFFF);
        check("R8 zero sample after underflow", dec[5], 0);
        check("R5 bit clock period", 32'(period_err), 0);
        check("R5 slot length", 32'(half_err), 0);
        bus_read(4'd6, rd);
        check("R8 underflow flag set", rd, 1);
        bus_read(4'd3, rd);
        check("R6 level empty after send", rd, 0);
        bus_write(4'd7, 32'h0);
        bus_write(4'd6, 32'h0);
        bus_read(4'd6, rd);
        check("R8 writing 0 keeps flag", rd, 1);
        bus_write(4'd6, 32'h1);
        bus_read(4'd6, rd);
        check("R8 write 1 clears flag", rd, 0);

        // R9: flush empties the FIFO and restarts the serialiser.
        for (int i = 0; i < 3; i++) bus_write(4'd9, 32'h1234 + 32'(i));
        bus_read(4'd3, rd);
        check("R9 level before flush", rd, 3);
        bus_write(4'd8, 32'h0);
        bus_read(4'd3, rd);
        check("R9 level after flush", rd, 0);
        for (int i = 0; i < 4; i++) bus_write(4'd9, 32'hFFFF);
        bus_write(4'd7, 32'h1);
        repeat (300) @(posedge clk);
        bus_write(4'd8, 32'h0);
        check("R9 clocks restart low", {30'b0, sclk_o, lrck_o}, 0);
        bus_read(4'd3, rd);
        check("R9 FIFO empty after mid-stream flush", rd, 0);
        bus_write(4'd7, 32'h0);
        bus_write(4'd6, 32'h1);

        // R6: overflow drops writes, level saturates, first 32 words sent.
        for (int i = 0; i < 34; i++) words[i] = {16'hBEE0 + 16'(i), 16'(i * 16'h0731 + 16'h0101)};
        for (int i = 0; i < 34; i++) bus_write(4'd9, words[i]);
        bus_read(4'd3, rd);
        check("R6 level saturates at 32", rd, 32);
        restart_decoder(8, 16, 16);
        bus_write(4'd7, 32'h1);
        wait_words(33);
        begin
            int bad = 0;
            for (int i = 0; i < 32; i++) if (dec[i] !== (words[i] & 32'hFFFF)) bad++;
            check("R6 first 32 words sent intact", 32'(bad), 0);
        end
        check("R6 dropped word not sent", dec[32], 0);
        bus_write(4'd7, 32'h0);
        bus_write(4'd6, 32'h1);

        // R10: 24-bit samples in a 48-bit frame, ratio 4.
        bus_write(4'd0, 32'd23);
        bus_write(4'd2, 32'h00032F2F);
        words[0] = 32'hAB123456; words[1] = 32'h00FEDCBA;
        words[2] = 32'h5A800001; words[3] = 32'hFFFFFFFF;
        for (int i = 0; i < 4; i++) bus_write(4'd9, words[i]);
        restart_decoder(4, 24, 24);
        bus_write(4'd7, 32'h1);
        wait_words(5);
        for (int i = 0; i < 4; i++) check("R10 24-bit sample", dec[i], words[i] & 32'h00FFFFFF);
        check("R5 period at ratio 4", 32'(period_err), 0);
        check("R5 slot length 24", 32'(half_err), 0);
        bus_write(4'd7, 32'h0);

        // R7: 16-bit samples padded into 32-bit slots, ratio 2.
        bus_write(4'd0, 32'd15);
        bus_write(4'd2, 32'h00013F3F);
        words[0] = 32'hFFFF8001; words[1] = 32'h00007FFE; words[2] = 32'h12340F0F;
        for (int i = 0; i < 3; i++) bus_write(4'd9, words[i]);
        restart_decoder(2, 32, 16);
        bus_write(4'd7, 32'h1);
        wait_words(4);
        for (int i = 0; i < 3; i++) check("R7 padded slot sample", dec[i], words[i] & 32'hFFFF);
        check("R5 period at ratio 2", 32'(period_err), 0);
        check("R5 slot length 32", 32'(half_err), 0);
        bus_write(4'd7, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule